// File: doc/BRIEF.md
# Calendar-Driven FIFO Status Sequencer

This block produces the 2-bit per-channel FIFO status stream of an SPI-4.2 style status channel. Software or setup logic first programs a channel calendar. Each calendar slot holds the number of the channel whose status goes out in that slot. The block then emits framed status frames continuously. Each frame is a framing word, then the calendar walked from slot 0 to slot `len` and repeated `rep+1` times, then a 2-bit diagonal parity word.

User logic supplies channel status through a 32-bit word that carries 16 channels, with a group address that selects which 16 channels are written. Calendar contents, calendar length and repeat count are captured at each frame boundary. A frame in progress therefore never mixes old and new settings. The status bank is read live, so a status write shows up in the next slot that names that channel.

Top module: `fifo_status_seq`

## Requirements
- R1: After reset every calendar entry and every status bit is zero, and the output carries the framing word 2'b11 with `frm_o` high. A single-channel system therefore sends channel 0's status with no calendar programming.
- R2: A calendar write takes place on a clock edge while `cal_wr_n` is low: `cal_wdata` is stored at `cal_addr`. While `cal_wr_n` is high, `cal_rdata` shows the stored entry at `cal_addr`. While it is low, `cal_rdata` is zero.
- R3: A frame is one framing cycle (`frm_o`=1, `stat_o`=2'b11), then exactly (len+1)*(rep+1) status cycles, then one parity cycle. The next frame's framing cycle follows at once.
- R4: Status cycle i of a frame carries the status of the channel held in calendar slot (i mod (len+1)). Slots are walked in ascending order, once per repetition.
- R5: Channel k's status is bits [2*(k mod 16)+1 : 2*(k mod 16)] of the word last written with group address k/16. The group is the upper 4 bits of the 8-bit channel number.
- R6: A status write with `stat_we` high stores `stat_wdata` into the addressed group only. It is visible from the cycle after the write edge, and other groups are unchanged.
- R7: The parity word is computed as follows. An accumulator starts at 2'b11. For each status word w of the frame, it becomes {acc[0],acc[1]} ^ w. The parity word sent is {acc[0],acc[1]} of the final accumulator.
- R8: Calendar contents, `cfg_len` and `cfg_rep` are taken as they stand at the clock edge that ends the framing cycle. Changes at any other time affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_wr_n | input | 1 | Calendar write strobe, active low |
| cal_addr | input | 9 | Calendar slot address for write and readback |
| cal_wdata | input | 8 | Channel number to store |
| cal_rdata | output | 8 | Readback of the slot at `cal_addr` |
| stat_we | input | 1 | Status group write enable |
| stat_grp | input | 4 | Status group address (channels 16*grp to 16*grp+15) |
| stat_wdata | input | 32 | 2-bit status for 16 channels |
| cfg_len | input | 9 | Calendar length minus one |
| cfg_rep | input | 8 | Calendar repetitions minus one |
| frm_o | output | 1 | High during the framing cycle |
| stat_o | output | 2 | Status channel word |

## Verification
A wrong slot pointer or a stale active calendar shows up within one status cycle as a word that belongs to the wrong channel. A miscounted repetition or length shifts the parity cycle and the next framing cycle, so the error is visible before the end of the frame. A corrupted parity accumulator appears only in the last cycle of the frame. For that reason every frame is checked through its parity word. Capture-timing faults show up when settings change mid-frame: the frame then carries the new length or calendar too early.

// File: rtl/fifo_status_seq.sv
module fifo_status_seq #(
  parameter int CAL_AW = 9,
  parameter int GRP_W  = 4,
  parameter int REP_W  = 8,
  localparam int CH_W  = GRP_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_wr_n,
  input  logic [CAL_AW-1:0] cal_addr,
  input  logic [CH_W-1:0]   cal_wdata,
  output logic [CH_W-1:0]   cal_rdata,
  input  logic              stat_we,
  input  logic [GRP_W-1:0]  stat_grp,
  input  logic [31:0]       stat_wdata,
  input  logic [CAL_AW-1:0] cfg_len,
  input  logic [REP_W-1:0]  cfg_rep,
  output logic              frm_o,
  output logic [1:0]        stat_o
);
  localparam int CAL_DEPTH = 2 ** CAL_AW;
  localparam int N_GRP     = 2 ** GRP_W;
  localparam logic [1:0] PH_FRM  = 2'd0;
  localparam logic [1:0] PH_SLOT = 2'd1;
  localparam logic [1:0] PH_DIP  = 2'd2;

  logic [CH_W-1:0]   usr_cal [CAL_DEPTH];
  logic [CH_W-1:0]   act_cal [CAL_DEPTH];
  logic [31:0]       bank    [N_GRP];
  logic [1:0]        phase;
  logic [CAL_AW-1:0] lat_len, slot_idx;
  logic [REP_W-1:0]  lat_rep, rep_idx;
  logic [1:0]        acc;

  wire [CH_W-1:0] cur_ch   = act_cal[slot_idx];
  wire [31:0]     cur_word = bank[cur_ch[CH_W-1:4]];
  wire [1:0]      cur_st   = cur_word[{cur_ch[3:0], 1'b0} +: 2];

  assign frm_o     = (phase == PH_FRM);
  assign stat_o    = (phase == PH_SLOT) ? cur_st :
                     (phase == PH_DIP)  ? {acc[0], acc[1]} : 2'b11;
  assign cal_rdata = cal_wr_n ? usr_cal[cal_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAL_DEPTH; i++) usr_cal[i] <= '0;
    end else if (!cal_wr_n) begin
      usr_cal[cal_addr] <= cal_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAL_DEPTH; i++) act_cal[i] <= '0;
    end else if (frm_o) begin
      for (int i = 0; i < CAL_DEPTH; i++) act_cal[i] <= usr_cal[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < N_GRP; g++) bank[g] <= '0;
    end else if (stat_we) begin
      bank[stat_grp] <= stat_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_FRM;
      lat_len  <= '0;
      lat_rep  <= '0;
      slot_idx <= '0;
      rep_idx  <= '0;
      acc      <= 2'b11;
    end else begin
      case (phase)
        PH_FRM: begin
          lat_len  <= cfg_len;
          lat_rep  <= cfg_rep;
          slot_idx <= '0;
          rep_idx  <= '0;
          acc      <= 2'b11;
          phase    <= PH_SLOT;
        end
        PH_SLOT: begin
          acc <= {acc[0], acc[1]} ^ cur_st;
          if (slot_idx == lat_len) begin
            slot_idx <= '0;
            if (rep_idx == lat_rep) phase <= PH_DIP;
            else rep_idx <= rep_idx + 1'b1;
          end else begin
            slot_idx <= slot_idx + 1'b1;
          end
        end
        default: phase <= PH_FRM;
      endcase
    end
  end
endmodule

module fifo_status_seq_chk #(
  parameter int CAL_AW = 9,
  parameter int REP_W  = 8,
  parameter int CH_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_wr_n,
  input logic [CAL_AW-1:0] cal_addr,
  input logic [CH_W-1:0]   cal_wdata,
  input logic [CH_W-1:0]   cal_rdata,
  input logic              frm_o,
  input logic [1:0]        phase,
  input logic [CAL_AW-1:0] slot_idx,
  input logic [CAL_AW-1:0] lat_len,
  input logic [REP_W-1:0]  rep_idx,
  input logic [REP_W-1:0]  lat_rep
);
  // R2
  cal_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cal_wr_n) && cal_wr_n && cal_addr == $past(cal_addr))
    |-> cal_rdata == $past(cal_wdata));
  // R3
  frm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_o |=> !frm_o);
  // R3
  dip_then_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> frm_o);
  // R3
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> (slot_idx <= lat_len && rep_idx <= lat_rep));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(frm_o)) |-> ($stable(lat_len) && $stable(lat_rep)));
endmodule

bind fifo_status_seq fifo_status_seq_chk #(.CAL_AW(CAL_AW), .REP_W(REP_W), .CH_W(CH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cal_wr_n(cal_wr_n), .cal_addr(cal_addr),
  .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .frm_o(frm_o), .phase(phase),
  .slot_idx(slot_idx), .lat_len(lat_len), .rep_idx(rep_idx), .lat_rep(lat_rep)
);

// File: tb/test_fifo_status_seq.sv
`timescale 1ns/1ps
module test_fifo_status_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cal_wr_n = 1;
  logic [8:0]  cal_addr = '0;
  logic [7:0]  cal_wdata = '0;
  logic [7:0]  cal_rdata;
  logic        stat_we = 0;
  logic [3:0]  stat_grp = '0;
  logic [31:0] stat_wdata = '0;
  logic [8:0]  cfg_len = '0;
  logic [7:0]  cfg_rep = '0;
  logic        frm_o;
  logic [1:0]  stat_o;

  always #5 clk = ~clk;

  fifo_status_seq i_fifo_status_seq (
    .clk(clk), .rst_n(rst_n), .cal_wr_n(cal_wr_n), .cal_addr(cal_addr),
    .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .stat_we(stat_we),
    .stat_grp(stat_grp), .stat_wdata(stat_wdata), .cfg_len(cfg_len),
    .cfg_rep(cfg_rep), .frm_o(frm_o), .stat_o(stat_o)
  );

  int vecs = 0, fails = 0;
  bit done = 0;
  logic [7:0]  m_cal [512];
  logic [7:0]  s_cal [512];
  logic [31:0] m_stat [16];

  function automatic logic [1:0] exp_st(input logic [7:0] ch);
    logic [31:0] w;
    w = m_stat[ch[7:4]];
    return w[{ch[3:0], 1'b0} +: 2];
  endfunction

  function automatic logic [1:0] dip_step(input logic [1:0] a, input logic [1:0] w);
    return {a[0], a[1]} ^ w;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  task automatic wr_cal(input logic [8:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cal_addr = a; cal_wdata = d; cal_wr_n = 0;
    #1 chk(cal_rdata == 8'd0, "R2 readback zero during write", cal_rdata, 0);
    @(posedge clk);
    m_cal[a] = d;
    #2 cal_wr_n = 1;
    #1 chk(cal_rdata == d, "R2 readback", cal_rdata, d);
  endtask

  task automatic wr_stat(input logic [3:0] g, input logic [31:0] d);
    @(posedge clk); #2;
    stat_grp = g; stat_wdata = d; stat_we = 1;
    @(posedge clk);
    m_stat[g] = d;
    #2 stat_we = 0;
  endtask

  task automatic set_cfg(input logic [8:0] l, input logic [7:0] r);
    @(posedge clk); #2;
    cfg_len = l; cfg_rep = r;
  endtask

  // frame monitor: R3, R4, R5, R6, R7, R8
  initial begin
    bit inframe = 0;
    int idx = 0, total = 0, s_len = 0;
    logic [1:0] acc = 2'b11, e;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (!inframe) begin
        chk(frm_o === 1'b1 && stat_o === 2'b11, "R3 framing word", {frm_o, stat_o}, 7);
        s_len = int'(cfg_len);
        total = (s_len + 1) * (int'(cfg_rep) + 1);
        for (int i = 0; i < 512; i++) s_cal[i] = m_cal[i];
        idx = 0; acc = 2'b11; inframe = 1;
      end else if (idx < total) begin
        e = exp_st(s_cal[idx % (s_len + 1)]);
        chk(frm_o === 1'b0 && stat_o === e, "R4/R5/R8 slot status", stat_o, e);
        acc = dip_step(acc, e);
        idx++;
      end else begin
        e = {acc[0], acc[1]};
        chk(frm_o === 1'b0 && stat_o === e, "R7 parity word", stat_o, e);
        inframe = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed = 11;
    void'($urandom(seed));
    for (int i = 0; i < 512; i++) m_cal[i] = '0;
    for (int g = 0; g < 16; g++) m_stat[g] = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(frm_o === 1'b1 && stat_o === 2'b11, "R1 reset framing", {frm_o, stat_o}, 7);
    @(posedge clk); #2 rst_n = 1;
    foreach (m_cal[i]) if (i == 0 || i == 5 || i == 511) begin
      cal_addr = 9'(i);
      #1 chk(cal_rdata == 8'd0, "R1 calendar zero after reset", cal_rdata, 0);
    end
    repeat (10) @(posedge clk);
    // R1 single channel needs no calendar; R6 group write
    wr_stat(4'd0, 32'h0000_0002);
    repeat (12) @(posedge clk);
    wr_stat(4'd3, 32'hFFFF_FFFF);
    repeat (8) @(posedge clk);
    // directed calendar CH3,CH0,CH1,CH2,CH3,CH0 (R4)
    wr_stat(4'd0, 32'h0000_00E4);
    wr_cal(9'd0, 8'd3); wr_cal(9'd1, 8'd0); wr_cal(9'd2, 8'd1);
    wr_cal(9'd3, 8'd2); wr_cal(9'd4, 8'd3); wr_cal(9'd5, 8'd0);
    set_cfg(9'd5, 8'd0);
    repeat (30) @(posedge clk);
    set_cfg(9'd5, 8'd2);
    repeat (50) @(posedge clk);
    // corners: long calendar, many repetitions (R3)
    set_cfg(9'd511, 8'd0);
    repeat (1100) @(posedge clk);
    set_cfg(9'd1, 8'd255);
    repeat (1100) @(posedge clk);
    // random mix; mid-frame changes exercise R8, live writes R6
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: wr_cal(9'($urandom % 24), 8'($urandom));
        3, 4, 5: wr_stat(4'($urandom), $urandom);
        6:       set_cfg(9'($urandom % 16), 8'($urandom % 4));
        default: repeat (1 + $urandom % 6) @(posedge clk);
      endcase
    end
    repeat (600) @(posedge clk);
    finish_run();
  end
endmodule